// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block brings a small 32-bit processor core out of reset. While reset is held it puts the architectural state that it owns into a known condition. The status word is forced into supervisor mode with interrupt mask level 7, with trace and the M bit cleared. The vector base is set to zero and every local memory-control enable is cleared. On the same clock edges it captures a 2-bit boot strap code from data pins. The code tells the rest of the chip which device answers at address zero and how wide its port is.

Once reset is released, the sequencer asks for the bus with a request/grant handshake. After the grant it runs two single-beat longword reads. The word at address 0 becomes the initial stack pointer and the word at address 4 becomes the initial program counter. It then gives the core a one-cycle pulse to begin fetching at that program counter. If the bus reports an error on either read, the sequencer stops in a halted state that only a new reset can leave. After start-up the core may rewrite the status word, vector base and memory enables through simple write strobes, but only once the sequence has completed.

Top module: `reset_vector_seq`

## Requirements
- R1: At every clock edge with `rst` high the block forces `statusReg` to 16'h2700, `vecBase` to 0, `memEnable` to all zeros, and `stackPtr` and `progCtr` to 0. The status value has trace at bit 15 = 0, supervisor at bit 13 = 1, M at bit 12 = 0 and mask bits 10:8 = 7. In the first cycle after release, `busReq`, `halted` and `startFetch` are low. Reset overrides every state.
- R2: `bootPins` is sampled at every clock edge where `rst` is high. The value from the last such edge is held on `bootExternal` and `bootWidth` until the next reset, whatever the pins do afterwards.
- R3: The boot code maps as follows: 00 gives internal 32-bit, 01 gives external 16-bit, 10 gives external 8-bit and 11 gives external 32-bit. `bootExternal` is 0 only for code 00. `bootWidth` is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit.
- R4: In the first cycle after reset is released, `busReq` rises and stays high. No read (`busRd`) is issued until `busGnt` has been sampled high.
- R5: The first read drives `busAddr` = 0 with `busRd` high. It waits for `busAck` for any number of cycles, and the `busRdata` sampled with the ack is loaded into `stackPtr`.
- R6: The second read, at `busAddr` = 4, starts only after the first read has been acknowledged. Its acknowledged data is loaded into `progCtr`.
- R7: `startFetch` is high for exactly one cycle: the cycle after the edge that acknowledged the second read. `busReq` is low from that cycle on.
- R8: `busErr` during either read takes precedence over `busAck`. The register of that read is not loaded, `halted` rises in the next cycle and stays high with `busReq` low until reset. `busErr` after start-up has no effect.
- R9: Core writes (`coreSrWe`, `coreVbrWe`, `coreMemEnWe`) change `statusReg`, `vecBase` or `memEnable` only after the sequence has completed. Writes before that are ignored.
- R10: Reset asserted in the middle of the fetch aborts it. After release, the sequence restarts with a new request and a read at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bootPins | input | 2 | Boot strap data pins |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| busRd | output | 1 | Read strobe |
| busAddr | output | ADDR_W | Read address |
| busRdata | input | DATA_W | Read data |
| busAck | input | 1 | Read acknowledge |
| busErr | input | 1 | Access or address error |
| coreSrWe | input | 1 | Core write of the status word |
| coreSrData | input | 16 | Status word write data |
| coreVbrWe | input | 1 | Core write of the vector base |
| coreVbrData | input | DATA_W | Vector base write data |
| coreMemEnWe | input | 1 | Core write of the memory enables |
| coreMemEnData | input | MEM_CTLS | Memory enable write data |
| statusReg | output | 16 | Status word |
| vecBase | output | DATA_W | Vector base |
| memEnable | output | MEM_CTLS | Local memory-control enables |
| stackPtr | output | DATA_W | Initial stack pointer |
| progCtr | output | DATA_W | Initial program counter |
| startFetch | output | 1 | One-cycle start pulse to the core |
| halted | output | 1 | Fault-on-fault halt flag |
| bootExternal | output | 1 | Boot device is external |
| bootWidth | output | 2 | Boot port width code |

## Verification
A sequencer stuck in the wrong state shows at the bus pins within one cycle. Examples are a read at the wrong address, a read issued before the grant, or a request that never drops. A wrong load strobe shows as the next cycle's `stackPtr` or `progCtr`. A lost or doubled start pulse, or a halt flag that clears or never sets, is visible in the cycle after the triggering acknowledge or error. The bench sweeps all four boot codes with distinct vector data, faults on each read, post-start errors, core writes before and after start-up, and a reset in the middle of the fetch.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  localparam int SR_W       = 16;
  localparam int SR_TRACE   = 15;
  localparam int SR_SUPER   = 13;
  localparam int SR_MBIT    = 12;
  localparam int SR_MASK_LO = 8;
  localparam int SR_MASK_W  = 3;

  typedef enum logic [2:0] {
    RESET_HOLD,
    WAIT_GRANT,
    READ_SP,
    READ_PC,
    RUN,
    HALT
  } seqState_t;

  typedef struct packed {
    logic forceReset;
    logic loadSp;
    logic loadPc;
    logic allowCore;
  } seqStrobe_t;

  function automatic logic [SR_W-1:0] srResetValue();
    logic [SR_W-1:0] v;
    v = '0;
    v[SR_TRACE] = 1'b0;
    v[SR_MBIT]  = 1'b0;
    v[SR_SUPER] = 1'b1;
    v[SR_MASK_LO +: SR_MASK_W] = '1;
    return v;
  endfunction

endpackage

// File: rtl/rvs_ctrl.sv
module rvs_ctrl
  import rvs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busGnt,
  input  logic              busAck,
  input  logic              busErr,
  output logic              busReq,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              halted,
  output seqStrobe_t        strobes
);

  localparam int VEC_STRIDE = DATA_W / 8;

  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= RESET_HOLD;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      RESET_HOLD: stateD = WAIT_GRANT;
      WAIT_GRANT: if (busGnt) stateD = READ_SP;
      READ_SP: begin
        if (busErr)      stateD = HALT;
        else if (busAck) stateD = READ_PC;
      end
      READ_PC: begin
        if (busErr)      stateD = HALT;
        else if (busAck) stateD = RUN;
      end
      RUN:     stateD = RUN;
      HALT:    stateD = HALT;
      default: stateD = RESET_HOLD;
    endcase
  end

  always_comb begin
    strobes.forceReset = rst;
    strobes.loadSp     = !rst && (stateQ == READ_SP) && busAck && !busErr;
    strobes.loadPc     = !rst && (stateQ == READ_PC) && busAck && !busErr;
    strobes.allowCore  = !rst && (stateQ == RUN);
  end

  assign busReq  = (stateQ == WAIT_GRANT) || (stateQ == READ_SP) || (stateQ == READ_PC);
  assign busRd   = (stateQ == READ_SP) || (stateQ == READ_PC);
  assign busAddr = (stateQ == READ_PC) ? ADDR_W'(VEC_STRIDE) : '0;
  assign halted  = (stateQ == HALT);

endmodule

// File: rtl/rvs_datapath.sv
module rvs_datapath
  import rvs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MEM_CTLS = 2
) (
  input  logic                clk,
  input  seqStrobe_t          strobes,
  input  logic [1:0]          bootPins,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                coreSrWe,
  input  logic [SR_W-1:0]     coreSrData,
  input  logic                coreVbrWe,
  input  logic [DATA_W-1:0]   coreVbrData,
  input  logic                coreMemEnWe,
  input  logic [MEM_CTLS-1:0] coreMemEnData,
  output logic [SR_W-1:0]     statusReg,
  output logic [DATA_W-1:0]   vecBase,
  output logic [MEM_CTLS-1:0] memEnable,
  output logic [DATA_W-1:0]   stackPtr,
  output logic [DATA_W-1:0]   progCtr,
  output logic                startFetch,
  output logic                bootExternal,
  output logic [1:0]          bootWidth
);

  localparam logic [SR_W-1:0] SR_RST = srResetValue();

  logic [1:0] bootCodeQ;

  always_ff @(posedge clk) begin
    if (strobes.forceReset) bootCodeQ <= bootPins;
  end

  always_comb begin
    bootExternal = |bootCodeQ;
    unique case (bootCodeQ)
      2'b01:   bootWidth = 2'd1;
      2'b10:   bootWidth = 2'd0;
      default: bootWidth = 2'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.forceReset) begin
      statusReg <= SR_RST;
      vecBase   <= '0;
    end else if (strobes.allowCore) begin
      if (coreSrWe)  statusReg <= coreSrData;
      if (coreVbrWe) vecBase   <= coreVbrData;
    end
  end

  for (genvar i = 0; i < MEM_CTLS; i++) begin : g_memEn
    always_ff @(posedge clk) begin
      if (strobes.forceReset)                   memEnable[i] <= 1'b0;
      else if (strobes.allowCore && coreMemEnWe) memEnable[i] <= coreMemEnData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.forceReset) begin
      stackPtr   <= '0;
      progCtr    <= '0;
      startFetch <= 1'b0;
    end else begin
      if (strobes.loadSp) stackPtr <= busRdata;
      if (strobes.loadPc) progCtr  <= busRdata;
      startFetch <= strobes.loadPc;
    end
  end

endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int MEM_CTLS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          bootPins,
  output logic                busReq,
  input  logic                busGnt,
  output logic                busRd,
  output logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busAck,
  input  logic                busErr,
  input  logic                coreSrWe,
  input  logic [15:0]         coreSrData,
  input  logic                coreVbrWe,
  input  logic [DATA_W-1:0]   coreVbrData,
  input  logic                coreMemEnWe,
  input  logic [MEM_CTLS-1:0] coreMemEnData,
  output logic [15:0]         statusReg,
  output logic [DATA_W-1:0]   vecBase,
  output logic [MEM_CTLS-1:0] memEnable,
  output logic [DATA_W-1:0]   stackPtr,
  output logic [DATA_W-1:0]   progCtr,
  output logic                startFetch,
  output logic                halted,
  output logic                bootExternal,
  output logic [1:0]          bootWidth
);

  seqStrobe_t strobes;

  rvs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busGnt  (busGnt),
    .busAck  (busAck),
    .busErr  (busErr),
    .busReq  (busReq),
    .busRd   (busRd),
    .busAddr (busAddr),
    .halted  (halted),
    .strobes (strobes)
  );

  rvs_datapath #(.DATA_W(DATA_W), .MEM_CTLS(MEM_CTLS)) u_dp (
    .clk           (clk),
    .strobes       (strobes),
    .bootPins      (bootPins),
    .busRdata      (busRdata),
    .coreSrWe      (coreSrWe),
    .coreSrData    (coreSrData),
    .coreVbrWe     (coreVbrWe),
    .coreVbrData   (coreVbrData),
    .coreMemEnWe   (coreMemEnWe),
    .coreMemEnData (coreMemEnData),
    .statusReg     (statusReg),
    .vecBase       (vecBase),
    .memEnable     (memEnable),
    .stackPtr      (stackPtr),
    .progCtr       (progCtr),
    .startFetch    (startFetch),
    .bootExternal  (bootExternal),
    .bootWidth     (bootWidth)
  );

endmodule

// File: rtl/reset_vector_seq_chk.sv
module reset_vector_seq_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int MEM_CTLS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                busReq,
  input logic                busRd,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [15:0]         statusReg,
  input logic [DATA_W-1:0]   vecBase,
  input logic [MEM_CTLS-1:0] memEnable,
  input logic [DATA_W-1:0]   stackPtr,
  input logic [DATA_W-1:0]   progCtr,
  input logic                startFetch,
  input logic                halted,
  input logic                bootExternal,
  input logic [1:0]          bootWidth
);

  // R1: the first cycle after release still shows the forced values
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (statusReg == 16'h2700 && vecBase == '0 && memEnable == '0 &&
                    stackPtr == '0 && progCtr == '0 && !busReq && !halted && !startFetch));

  // R2: boot code held once reset has been low for a full cycle
  assert_boot_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable({bootExternal, bootWidth}));

  // R3: internal boot is always 32-bit wide
  assert_boot_width_R3: assert property (@(posedge clk) disable iff (rst)
    !bootExternal |-> bootWidth == 2'd2);

  // R4: reads only under an active request
  assert_read_under_req_R4: assert property (@(posedge clk) disable iff (rst)
    busRd |-> busReq);

  // R5 and R6: only the two vector addresses are read
  assert_vec_addr_R6: assert property (@(posedge clk) disable iff (rst)
    busRd |-> (busAddr == '0 || busAddr == ADDR_W'(DATA_W / 8)));

  // R7: start pulse lasts one cycle and the bus is free meanwhile
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    startFetch |=> !startFetch);

  assert_start_no_req_R7: assert property (@(posedge clk) disable iff (rst)
    startFetch |-> !busReq);

  // R8: halt is sticky and quiet on the bus
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !busReq && !startFetch));

endmodule

bind reset_vector_seq reset_vector_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_CTLS(MEM_CTLS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busReq       (busReq),
  .busRd        (busRd),
  .busAddr      (busAddr),
  .statusReg    (statusReg),
  .vecBase      (vecBase),
  .memEnable    (memEnable),
  .stackPtr     (stackPtr),
  .progCtr      (progCtr),
  .startFetch   (startFetch),
  .halted       (halted),
  .bootExternal (bootExternal),
  .bootWidth    (bootWidth)
);

// File: tb/reset_vector_seq_tb.sv
module reset_vector_seq_tb;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 32;
  localparam int MEM_CTLS = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [1:0]          bootPins = 2'b00;
  logic                busReq, busRd;
  logic                busGnt = 1'b0;
  logic [ADDR_W-1:0]   busAddr;
  logic [DATA_W-1:0]   busRdata = '0;
  logic                busAck = 1'b0;
  logic                busErr = 1'b0;
  logic                coreSrWe = 1'b0;
  logic [15:0]         coreSrData = '0;
  logic                coreVbrWe = 1'b0;
  logic [DATA_W-1:0]   coreVbrData = '0;
  logic                coreMemEnWe = 1'b0;
  logic [MEM_CTLS-1:0] coreMemEnData = '0;
  logic [15:0]         statusReg;
  logic [DATA_W-1:0]   vecBase, stackPtr, progCtr;
  logic [MEM_CTLS-1:0] memEnable;
  logic                startFetch, halted, bootExternal;
  logic [1:0]          bootWidth;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  reset_vector_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_CTLS(MEM_CTLS)) u_dut (
    .clk(clk), .rst(rst), .bootPins(bootPins),
    .busReq(busReq), .busGnt(busGnt), .busRd(busRd), .busAddr(busAddr),
    .busRdata(busRdata), .busAck(busAck), .busErr(busErr),
    .coreSrWe(coreSrWe), .coreSrData(coreSrData),
    .coreVbrWe(coreVbrWe), .coreVbrData(coreVbrData),
    .coreMemEnWe(coreMemEnWe), .coreMemEnData(coreMemEnData),
    .statusReg(statusReg), .vecBase(vecBase), .memEnable(memEnable),
    .stackPtr(stackPtr), .progCtr(progCtr), .startFetch(startFetch),
    .halted(halted), .bootExternal(bootExternal), .bootWidth(bootWidth)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkResetState(string tag);
    checkEq({tag, " R1 statusReg"}, 32'(statusReg), 32'h2700);
    checkEq({tag, " R1 vecBase"}, vecBase, 32'h0);
    checkEq({tag, " R1 memEnable"}, 32'(memEnable), 32'h0);
    checkEq({tag, " R1 stackPtr"}, stackPtr, 32'h0);
    checkEq({tag, " R1 progCtr"}, progCtr, 32'h0);
    checkEq({tag, " R1 startFetch"}, 32'(startFetch), 32'h0);
  endtask

  // errAt: 0 = fault on first read, 1 = fault on second read, 2 = no fault
  task automatic runSeq(logic [1:0] code, logic [31:0] sp, logic [31:0] pc, int errAt, int ackWait);
    logic       expExt;
    logic [1:0] expWidth;
    expExt   = (code != 2'b00);
    expWidth = (code == 2'b10) ? 2'd0 : (code == 2'b01) ? 2'd1 : 2'd2;
    rst = 1'b1; bootPins = code; busGnt = 1'b0; busAck = 1'b0; busErr = 1'b0;
    step(); step();
    checkResetState("reset");
    checkEq("R1 halted in reset", 32'(halted), 32'h0);
    rst = 1'b0;
    step();
    // first cycle after release: request up, boot code latched
    checkEq("R4 busReq after release", 32'(busReq), 32'h1);
    bootPins = ~code;
    checkEq("R3 bootExternal", 32'(bootExternal), 32'(expExt));
    checkEq("R3 bootWidth", 32'(bootWidth), 32'(expWidth));
    // R9: core write before start-up is ignored
    coreSrWe = 1'b1; coreSrData = 16'h0000; coreVbrWe = 1'b1; coreVbrData = 32'hDEAD0000;
    coreMemEnWe = 1'b1; coreMemEnData = '1;
    step();
    coreSrWe = 1'b0; coreVbrWe = 1'b0; coreMemEnWe = 1'b0;
    checkEq("R9 early sr write ignored", 32'(statusReg), 32'h2700);
    checkEq("R9 early vbr write ignored", vecBase, 32'h0);
    checkEq("R9 early memEn write ignored", 32'(memEnable), 32'h0);
    checkEq("R2 bootExternal held", 32'(bootExternal), 32'(expExt));
    checkEq("R2 bootWidth held", 32'(bootWidth), 32'(expWidth));
    checkEq("R4 no read before grant", 32'(busRd), 32'h0);
    busGnt = 1'b1;
    step();
    busGnt = 1'b0;
    checkEq("R5 first read strobe", 32'(busRd), 32'h1);
    checkEq("R5 first read addr", busAddr, 32'h0);
    for (int w = 0; w < ackWait; w++) begin
      step();
      checkEq("R5 waits for ack addr", busAddr, 32'h0);
      checkEq("R5 sp not loaded early", stackPtr, 32'h0);
    end
    busRdata = sp; busAck = 1'b1; busErr = (errAt == 0);
    step();
    busAck = 1'b0; busErr = 1'b0;
    if (errAt == 0) begin
      checkEq("R8 halted after first-read fault", 32'(halted), 32'h1);
      checkEq("R8 sp not loaded on fault", stackPtr, 32'h0);
      checkEq("R8 busReq low when halted", 32'(busReq), 32'h0);
    end else begin
      checkEq("R5 sp loaded", stackPtr, sp);
      checkEq("R6 second read addr", busAddr, 32'h4);
      checkEq("R6 second read strobe", 32'(busRd), 32'h1);
      checkEq("R6 pc not yet loaded", progCtr, 32'h0);
      busRdata = pc; busAck = 1'b1; busErr = (errAt == 1);
      step();
      busAck = 1'b0; busErr = 1'b0;
      if (errAt == 1) begin
        checkEq("R8 halted after second-read fault", 32'(halted), 32'h1);
        checkEq("R8 pc not loaded on fault", progCtr, 32'h0);
        checkEq("R8 no start pulse on fault", 32'(startFetch), 32'h0);
      end else begin
        checkEq("R6 pc loaded", progCtr, pc);
        checkEq("R7 start pulse", 32'(startFetch), 32'h1);
        checkEq("R7 busReq dropped", 32'(busReq), 32'h0);
        step();
        checkEq("R7 start pulse one cycle", 32'(startFetch), 32'h0);
        // R8: error after start-up has no effect
        busErr = 1'b1;
        step();
        busErr = 1'b0;
        checkEq("R8 late error ignored", 32'(halted), 32'h0);
      end
    end
    if (errAt != 2) begin
      for (int h = 0; h < 3; h++) begin
        busGnt = 1'b1;
        step();
        checkEq("R8 halt sticky", 32'(halted), 32'h1);
        checkEq("R8 no read when halted", 32'(busRd), 32'h0);
      end
      busGnt = 1'b0;
    end
  endtask

  initial begin
    step();
    // sweep the four boot codes with distinct vectors and ack delays
    for (int c = 0; c < 4; c++) begin
      runSeq(2'(c), 32'h2000_0000 + 32'(c) * 32'h0001_1000,
             32'h0000_0400 + 32'(c) * 32'h40, 2, c);
    end

    // R9: core writes after start-up take effect, reset restores defaults
    coreSrWe = 1'b1; coreSrData = 16'h0412; coreVbrWe = 1'b1; coreVbrData = 32'h0010_0000;
    coreMemEnWe = 1'b1; coreMemEnData = 2'b10;
    step();
    coreSrWe = 1'b0; coreVbrWe = 1'b0; coreMemEnWe = 1'b0;
    checkEq("R9 sr written after start", 32'(statusReg), 32'h0412);
    checkEq("R9 vbr written after start", vecBase, 32'h0010_0000);
    checkEq("R9 memEn written after start", 32'(memEnable), 32'h2);
    rst = 1'b1;
    step();
    checkResetState("R1 after core writes");

    // faults on each read
    runSeq(2'b01, 32'h1111_0000, 32'h2222_0000, 0, 1);
    runSeq(2'b10, 32'h3333_0000, 32'h4444_0000, 1, 0);
    rst = 1'b1;
    step();
    checkEq("R1 reset clears halt", 32'(halted), 32'h0);

    // R10: reset during the second read aborts and restarts at address 0
    rst = 1'b1; step(); rst = 1'b0; step();
    busGnt = 1'b1; step(); busGnt = 1'b0;
    busRdata = 32'h5555_0000; busAck = 1'b1; step(); busAck = 1'b0;
    checkEq("R10 mid-sequence addr", busAddr, 32'h4);
    rst = 1'b1;
    step();
    checkEq("R10 bus released by reset", 32'(busReq), 32'h0);
    checkEq("R10 sp cleared by reset", stackPtr, 32'h0);
    rst = 1'b0;
    step();
    busGnt = 1'b1; step(); busGnt = 1'b0;
    checkEq("R10 restart addr", busAddr, 32'h0);
    checkEq("R10 restart read", 32'(busRd), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule